// File: doc/BRIEF.md
# Triple-Receiver CRC Voting Selector

A response frame from a remote node is captured by three receivers at once: one on the high wire, one on the low wire, and one that adds the two currents to reject common-mode noise. Each receiver delivers a frame of data bits followed by check bits. This block checks the CRC of each capture and compares the captures pairwise, bit by bit. From these results it picks which capture feeds each of two independent host read paths, and it decides whether the frame is flagged as erroneous.

The upstream capture logic presents all three frames and pulses `frameDone` for one cycle. On the next clock edge the block loads the data field chosen for each path into that path's own holding register, and it loads the error flag. Outputs then hold their values until the next strobe. Path A normally follows the high receiver and path B the low receiver. The summed capture replaces one or both of them only when the CRC results show that it is the more trustworthy source.

Top module: `crc_vote_sel`

## Requirements
- R1: While `rstN` is low, `wordA`, `wordB` and `errFlag` are all 0.
- R2: The outputs change only on the clock edge at which `frameDone` is sampled high. On every other edge all three outputs keep their values.
- R3: A frame is `{data[DATA_W-1:0], check[CRC_W-1:0]}`, with the check field in the low bits. It passes when `check` equals the remainder of a shift register that starts at zero and is clocked through the data bits MSB first. Each step shifts left, and the polynomial `CRC_POLY` is XORed in whenever the bit leaving the top XORed with the data bit is 1. An output word is the data field of the selected frame.
- R4: When the high and low frames both pass, whatever the sum frame's result: path A takes high and path B takes low. The error flag is 0 if the two full frames are identical and 1 otherwise.
- R5: When high and sum pass and low fails: path A takes high. If high equals sum, the error flag is 0 and path B takes sum. Otherwise the error flag is 1 and path B takes low.
- R6: When low and sum pass and high fails: path B takes low. If low equals sum, the error flag is 0 and path A takes sum. Otherwise the error flag is 1 and path A takes high.
- R7: When only the sum frame passes, both paths take sum and the error flag is 0.
- R8: When only high passes, only low passes, or no frame passes, the error flag is 1, path A takes high and path B takes low.
- R9: If the full high frame or the full low frame, check bits included, is all ones, the error flag is 1. This overrides R4 to R7. Path selection is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameDone | input | 1 | One-cycle strobe: all three frames are valid |
| frmHi | input | FRAME_W | Frame from the high-wire receiver |
| frmLo | input | FRAME_W | Frame from the low-wire receiver |
| frmSum | input | FRAME_W | Frame from the summing receiver |
| wordA | output | DATA_W | Data word selected for host path A |
| wordB | output | DATA_W | Data word selected for host path B |
| errFlag | output | 1 | Frame error flag |

## Verification
The bench first drives each CRC pass pattern with the compared frames equal, then again with them different. A selector that swapped the roles of the two paths, or that ignored the pairwise comparison, would therefore load the wrong receiver's data or clear the flag on a disagreement. All-ones high or low frames are applied, including in the only-sum-passes case. A design that forgot the override would report a clean frame there. Frames are also changed while the strobe is low, so a design that reloaded on every edge would drift away from the held values. A long random run of good and corrupted frames covers the remaining combinations.

// File: rtl/crc_vote_pkg.sv
package crc_vote_pkg;

  typedef enum logic [1:0] {
    SRC_HI  = 2'd0,
    SRC_LO  = 2'd1,
    SRC_SUM = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic    load;
    srcSel_e srcA;
    srcSel_e srcB;
    logic    err;
  } voteStrb_t;

endpackage

// File: rtl/crc_frame_check.sv
module crc_frame_check #(
  parameter int                 DATA_W   = 8,
  parameter int                 CRC_W    = 4,
  parameter logic [CRC_W-1:0]   CRC_POLY = 4'h3,
  localparam int                FRAME_W  = DATA_W + CRC_W
) (
  input  logic [FRAME_W-1:0] frame,
  output logic               pass
);

  logic [CRC_W-1:0] remainder;
  logic             feedBit;

  always_comb begin
    remainder = '0;
    feedBit   = 1'b0;
    for (int i = FRAME_W - 1; i >= CRC_W; i--) begin
      feedBit   = remainder[CRC_W-1] ^ frame[i];
      remainder = remainder << 1;
      if (feedBit) remainder = remainder ^ CRC_POLY;
    end
    pass = (remainder == frame[CRC_W-1:0]);
  end

endmodule

// File: rtl/crc_vote_ctrl.sv
module crc_vote_ctrl
  import crc_vote_pkg::*;
(
  input  logic      frameDone,
  input  logic      passHi,
  input  logic      passLo,
  input  logic      passSum,
  input  logic      matchHiLo,
  input  logic      matchHiSum,
  input  logic      matchLoSum,
  input  logic      onesHi,
  input  logic      onesLo,
  output voteStrb_t strb
);

  logic [2:0] passVec;
  logic       voteErr;

  assign passVec = {passHi, passLo, passSum};

  always_comb begin
    strb.load = frameDone;
    strb.srcA = SRC_HI;
    strb.srcB = SRC_LO;
    voteErr   = 1'b1;
    unique case (passVec)
      3'b111, 3'b110: voteErr = ~matchHiLo;
      3'b101: begin
        if (matchHiSum) begin
          voteErr   = 1'b0;
          strb.srcB = SRC_SUM;
        end
      end
      3'b011: begin
        if (matchLoSum) begin
          voteErr   = 1'b0;
          strb.srcA = SRC_SUM;
        end
      end
      3'b001: begin
        voteErr   = 1'b0;
        strb.srcA = SRC_SUM;
        strb.srcB = SRC_SUM;
      end
      default: voteErr = 1'b1;
    endcase
    strb.err = voteErr | onesHi | onesLo;
  end

endmodule

// File: rtl/crc_vote_dp.sv
module crc_vote_dp
  import crc_vote_pkg::*;
#(
  parameter int  DATA_W  = 8,
  parameter int  CRC_W   = 4,
  localparam int FRAME_W = DATA_W + CRC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FRAME_W-1:0] frmHi,
  input  logic [FRAME_W-1:0] frmLo,
  input  logic [FRAME_W-1:0] frmSum,
  input  voteStrb_t          strb,
  output logic               matchHiLo,
  output logic               matchHiSum,
  output logic               matchLoSum,
  output logic               onesHi,
  output logic               onesLo,
  output logic [DATA_W-1:0]  wordA,
  output logic [DATA_W-1:0]  wordB,
  output logic               errFlag
);

  logic [DATA_W-1:0] dataHi, dataLo, dataSum;
  logic [DATA_W-1:0] nextA, nextB;

  assign matchHiLo  = ~|(frmHi ^ frmLo);
  assign matchHiSum = ~|(frmHi ^ frmSum);
  assign matchLoSum = ~|(frmLo ^ frmSum);
  assign onesHi     = &frmHi;
  assign onesLo     = &frmLo;

  assign dataHi  = frmHi[FRAME_W-1 -: DATA_W];
  assign dataLo  = frmLo[FRAME_W-1 -: DATA_W];
  assign dataSum = frmSum[FRAME_W-1 -: DATA_W];

  always_comb begin
    unique case (strb.srcA)
      SRC_SUM: nextA = dataSum;
      SRC_LO:  nextA = dataLo;
      default: nextA = dataHi;
    endcase
    unique case (strb.srcB)
      SRC_SUM: nextB = dataSum;
      SRC_HI:  nextB = dataHi;
      default: nextB = dataLo;
    endcase
  end

  // each host path owns its holding register, so a sum substitution on one
  // path never disturbs the other
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordA   <= '0;
      wordB   <= '0;
      errFlag <= 1'b0;
    end else if (strb.load) begin
      wordA   <= nextA;
      wordB   <= nextB;
      errFlag <= strb.err;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(wordA) && $stable(wordB) && $stable(errFlag)));

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (errFlag == $past(strb.err)));

endmodule

// File: rtl/crc_vote_sel.sv
module crc_vote_sel
  import crc_vote_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                CRC_W    = 4,
  parameter logic [CRC_W-1:0]  CRC_POLY = 4'h3,
  localparam int               FRAME_W  = DATA_W + CRC_W,
  localparam int               N_RX     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameDone,
  input  logic [FRAME_W-1:0] frmHi,
  input  logic [FRAME_W-1:0] frmLo,
  input  logic [FRAME_W-1:0] frmSum,
  output logic [DATA_W-1:0]  wordA,
  output logic [DATA_W-1:0]  wordB,
  output logic               errFlag
);

  logic [FRAME_W-1:0] rxFrame [N_RX];
  logic [N_RX-1:0]    rxPass;
  voteStrb_t          strb;
  logic               matchHiLo, matchHiSum, matchLoSum, onesHi, onesLo;

  assign rxFrame[0] = frmHi;
  assign rxFrame[1] = frmLo;
  assign rxFrame[2] = frmSum;

  for (genvar g = 0; g < N_RX; g++) begin : g_chk
    crc_frame_check #(
      .DATA_W  (DATA_W),
      .CRC_W   (CRC_W),
      .CRC_POLY(CRC_POLY)
    ) u_chk (
      .frame(rxFrame[g]),
      .pass (rxPass[g])
    );
  end

  crc_vote_ctrl u_ctrl (
    .frameDone (frameDone),
    .passHi    (rxPass[0]),
    .passLo    (rxPass[1]),
    .passSum   (rxPass[2]),
    .matchHiLo (matchHiLo),
    .matchHiSum(matchHiSum),
    .matchLoSum(matchLoSum),
    .onesHi    (onesHi),
    .onesLo    (onesLo),
    .strb      (strb)
  );

  crc_vote_dp #(
    .DATA_W(DATA_W),
    .CRC_W (CRC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .frmHi     (frmHi),
    .frmLo     (frmLo),
    .frmSum    (frmSum),
    .strb      (strb),
    .matchHiLo (matchHiLo),
    .matchHiSum(matchHiSum),
    .matchLoSum(matchLoSum),
    .onesHi    (onesHi),
    .onesLo    (onesLo),
    .wordA     (wordA),
    .wordB     (wordB),
    .errFlag   (errFlag)
  );

  logic allOnesAny;
  assign allOnesAny = (&frmHi) | (&frmLo);

  p_agree_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && rxPass[0] && rxPass[1] && !allOnesAny)
      |=> (errFlag == ($past(frmHi) != $past(frmLo)) &&
           wordA == $past(frmHi[FRAME_W-1 -: DATA_W]) &&
           wordB == $past(frmLo[FRAME_W-1 -: DATA_W])));

  p_hisum_r5: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && rxPass[0] && !rxPass[1] && rxPass[2])
      |=> (wordA == $past(frmHi[FRAME_W-1 -: DATA_W])));

  p_losum_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !rxPass[0] && rxPass[1] && rxPass[2])
      |=> (wordB == $past(frmLo[FRAME_W-1 -: DATA_W])));

  p_sumonly_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && rxPass == 3'b100 && !allOnesAny)
      |=> (!errFlag && wordA == wordB));

  p_nosum_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !rxPass[2] && !(rxPass[0] && rxPass[1])) |=> errFlag);

  p_ones_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && allOnesAny) |=> errFlag);

  always_comb begin
    if (!rstN) p_reset_r1: assert (wordA == '0 && wordB == '0 && !errFlag);
  end

endmodule

// File: tb/crc_vote_sel_bench.sv
module crc_vote_sel_bench;

  localparam int         DW   = 8;
  localparam int         CW   = 4;
  localparam int         FW   = DW + CW;
  localparam logic [CW-1:0] POLY = 4'h3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameDone = 1'b0;
  logic [FW-1:0] frmHi = '0, frmLo = '0, frmSum = '0;
  logic [DW-1:0] wordA, wordB;
  logic          errFlag;

  int checks = 0;
  int failures = 0;
  string lastReq = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  crc_vote_sel u_crc_vote_sel (
    .clk(clk), .rstN(rstN), .frameDone(frameDone),
    .frmHi(frmHi), .frmLo(frmLo), .frmSum(frmSum),
    .wordA(wordA), .wordB(wordB), .errFlag(errFlag)
  );

  // polynomial long division of data * x^CW, written independently
  function automatic logic [CW-1:0] refCrc(input logic [DW-1:0] d);
    logic [FW-1:0] v;
    v = {d, {CW{1'b0}}};
    for (int i = FW - 1; i >= CW; i--)
      if (v[i]) v[i -: CW+1] = v[i -: CW+1] ^ {1'b1, POLY};
    return v[CW-1:0];
  endfunction

  function automatic logic [FW-1:0] good(input logic [DW-1:0] d);
    return {d, refCrc(d)};
  endfunction

  function automatic logic [FW-1:0] bad(input logic [DW-1:0] d);
    return {d, refCrc(d) ^ 4'h1};
  endfunction

  function automatic bit ok(input logic [FW-1:0] f);
    return refCrc(f[FW-1:CW]) == f[CW-1:0];
  endfunction

  logic [DW-1:0] expA = '0, expB = '0;
  logic          expE = 1'b0;

  // reference model, updated on every clock from the requirement text
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expA <= '0; expB <= '0; expE <= 1'b0;
    end else if (frameDone) begin
      logic [DW-1:0] hD, lD, sD, a, b;
      bit pH, pL, pS, e;
      hD = frmHi[FW-1:CW]; lD = frmLo[FW-1:CW]; sD = frmSum[FW-1:CW];
      pH = ok(frmHi); pL = ok(frmLo); pS = ok(frmSum);
      a = hD; b = lD; e = 1;
      if (pH && pL) e = (frmHi != frmLo);
      else if (pH && pS) begin
        if (frmHi == frmSum) begin e = 0; b = sD; end
      end else if (pL && pS) begin
        if (frmLo == frmSum) begin e = 0; a = sD; end
      end else if (pS) begin
        e = 0; a = sD; b = sD;
      end
      if (frmHi == '1 || frmLo == '1) e = 1;
      expA <= a; expB <= b; expE <= e;
    end
  end

  task automatic checkNow();
    checks++;
    if (wordA !== expA || wordB !== expB || errFlag !== expE) begin
      failures++;
      $display("FAIL %s: actual A=%h B=%h err=%b expected A=%h B=%h err=%b",
               lastReq, wordA, wordB, errFlag, expA, expB, expE);
    end
  endtask

  task automatic step(input string req, input logic [FW-1:0] h,
                      input logic [FW-1:0] l, input logic [FW-1:0] s,
                      input logic fd);
    @(negedge clk);
    checkNow();
    lastReq = req;
    frmHi = h; frmLo = l; frmSum = s; frameDone = fd;
  endtask

  initial begin
    lastReq = "R1";
    repeat (3) begin @(negedge clk); checkNow(); end
    rstN = 1'b1;
    // R4: all pass, equal; then all pass, different; then sum fails
    step("R4", good(8'h5A), good(8'h5A), good(8'h5A), 1);
    step("R4", good(8'h11), good(8'h22), good(8'h11), 1);
    step("R4", good(8'h3C), good(8'h3C), bad(8'h77), 1);
    // R5: high and sum pass, low fails
    step("R5", good(8'h81), bad(8'h40), good(8'h81), 1);
    step("R5", good(8'h81), bad(8'h40), good(8'h82), 1);
    // R6: low and sum pass, high fails
    step("R6", bad(8'h09), good(8'hC3), good(8'hC3), 1);
    step("R6", bad(8'h09), good(8'hC3), good(8'hC4), 1);
    // R7: only sum passes
    step("R7", bad(8'h01), bad(8'h02), good(8'hE7), 1);
    // R8: only high, only low, none
    step("R8", good(8'h10), bad(8'h20), bad(8'h30), 1);
    step("R8", bad(8'h10), good(8'h20), bad(8'h30), 1);
    step("R8", bad(8'h44), bad(8'h55), bad(8'h66), 1);
    // R9: all-ones override, including the only-sum case
    step("R9", {FW{1'b1}}, bad(8'h12), good(8'h12), 1);
    step("R9", bad(8'h13), {FW{1'b1}}, good(8'h6B), 1);
    step("R9", good(8'hA5), {FW{1'b1}}, good(8'hA5), 1);
    // R2: inputs change without the strobe; outputs must hold
    step("R2", good(8'h01), good(8'h01), good(8'h01), 0);
    step("R2", bad(8'hF0), good(8'h0F), good(8'h77), 0);
    step("R2", good(8'h99), good(8'h99), good(8'h99), 1);
    // R3: random mix of corrupted and good frames
    for (int n = 0; n < 400; n++) begin
      logic [DW-1:0] d0, d1, d2;
      logic [FW-1:0] h, l, s;
      int r;
      d0 = 8'($urandom); r = $urandom % 4;
      d1 = (r == 0) ? d0 : 8'($urandom);
      d2 = ($urandom % 2) ? d0 : ((r == 1) ? d1 : 8'($urandom));
      h = ($urandom % 3) ? good(d0) : bad(d0);
      l = ($urandom % 3) ? good(d1) : bad(d1);
      s = ($urandom % 3) ? good(d2) : bad(d2);
      if ($urandom % 40 == 0) h = '1;
      step("R3", h, l, s, ($urandom % 4) != 0);
    end
    step("R2", '0, '0, '0, 0);
    @(negedge clk); checkNow();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule